// File: doc/BRIEF.md
# Column-Parallel SAR Conversion Sequencer

This block sequences one bank of column-parallel successive-approximation converters while a pixel row is being digitized. A single accepted start request walks the bank through three preparation phases in fixed order. First the pixel reset level is sampled, then the pixel signal level, and finally the converters correct their offset. The block then runs a shared binary search of `NBITS` steps from the most significant bit down. Every column's comparator decision lands in that column's own result register. The same trial-bit pattern is therefore shared by all `NCOL` columns, while each column builds its own code.

The trial code driven to the converter bank is the weight of the bit under test: mid-scale in the first search cycle, then halved on each following cycle. Each column's analog side compares its input against its own accumulated code plus that weight, and reports one comparator bit. A sleep input holds the converters disabled. While it is high, start requests are refused, and a conversion already running is abandoned. Phase lengths are parameters.

Top module: `col_sar_ctrl`

## Requirements
- R1: While reset is applied and just after it is released, `done`, all three phase strobes, `conv_en` and `trial_code` are 0, and every column result is 0.
- R2: An accepted start yields, with no gaps, `samp_rst` high for `RST_CYC` cycles, then `samp_sig` for `SIG_CYC` cycles, then `ofs_cor` for `OFS_CYC` cycles; signal sampling begins exactly `RST_CYC` cycles after reset sampling begins.
- R3: The `NBITS` search cycles start directly after the offset phase. In search cycle k (k = 0 first), `trial_code` equals `1 << (NBITS-1-k)`, so the first value is 512 for 10 bits.
- R4: All column results are cleared to 0 in the cycle after a start is accepted. In each search cycle, result bit `NBITS-1-k` of column c takes the value of `col_cmp[c]`, where 1 means the input is at or above the trial level. Column c's result occupies bits `[c*NBITS +: NBITS]` of `results` and shows the partial code while the search runs.
- R5: With an ideal comparator, each column's final result equals that column's input code, independently of every other column.
- R6: `done` is high for exactly one cycle. It rises `RST_CYC+SIG_CYC+OFS_CYC+NBITS` clock edges after the edge that accepted start.
- R7: A start raised while a conversion is in progress is ignored. It neither restarts nor extends the conversion, and no second conversion follows it.
- R8: After `done`, results hold unchanged whatever `col_cmp` does, until the next accepted start.
- R9: While `sleep` is high, `conv_en` is 0 from the next cycle and start is refused. Raising `sleep` during a conversion returns the block to idle, with every strobe and `trial_code` at 0 and no `done`.
- R10: At most one of the three phase strobes and a nonzero `trial_code` is active in any cycle, and `trial_code` is one-hot or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to convert one row |
| sleep | input | 1 | Hold converters disabled; abandon a conversion |
| col_cmp | input | NCOL | Per-column comparator result, 1 = input at or above trial level |
| conv_en | output | 1 | Converter bank enable |
| samp_rst | output | 1 | Reset-level sampling strobe |
| samp_sig | output | 1 | Signal-level sampling strobe |
| ofs_cor | output | 1 | Offset-correction strobe |
| trial_code | output | NBITS | Weight of the bit under test, zero outside the search |
| results | output | NCOL*NBITS | Per-column conversion codes |
| done | output | 1 | One-cycle pulse when the row is converted |

## Verification
The first reset-sampling strobe is visible in the cycle after the edge that accepts start. Each phase and search cycle follows one edge apart, and `done` appears in cycle `RST_CYC+SIG_CYC+OFS_CYC+NBITS+1` counted from that accepting edge. The bench drives inputs and samples outputs on falling edges, numbering each sample from the accepting edge, and compares the first cycle of each strobe, the strobe lengths and the cycle of `done` with those counts. Sleep responses are checked one edge after `sleep` changes. Final column codes are checked in the `done` cycle, and again after many further cycles in which the comparator inputs change.

// File: rtl/col_sar_pkg.sv
package col_sar_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RST  = 3'd1,
    ST_SIG  = 3'd2,
    ST_OFS  = 3'd3,
    ST_SRCH = 3'd4
  } conv_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/col_sar_seq.sv
module col_sar_seq
  import col_sar_pkg::*;
#(
  parameter int NBITS   = 10,
  parameter int RST_CYC = 3,
  parameter int SIG_CYC = 3,
  parameter int OFS_CYC = 2,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sleep,
  output conv_state_e   state_o,
  output logic [CW-1:0] step_o,
  output logic          accept_o,
  output logic          done_o,
  output logic          conv_en_o
);
  conv_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          en_q;
  logic          last;

  assign last     = (cnt_q == '0);
  assign accept_o = (state_q == ST_IDLE) && start && !sleep;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (sleep) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_d = ST_RST;
          cnt_d   = CW'(RST_CYC - 1);
        end
        ST_RST: if (last) begin
          state_d = ST_SIG;
          cnt_d   = CW'(SIG_CYC - 1);
        end else cnt_d = cnt_q - 1'b1;
        ST_SIG: if (last) begin
          state_d = ST_OFS;
          cnt_d   = CW'(OFS_CYC - 1);
        end else cnt_d = cnt_q - 1'b1;
        ST_OFS: if (last) begin
          state_d = ST_SRCH;
          cnt_d   = CW'(NBITS - 1);
        end else cnt_d = cnt_q - 1'b1;
        ST_SRCH: if (last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else cnt_d = cnt_q - 1'b1;
        default: begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      en_q    <= !sleep;
    end
  end

  assign state_o   = state_q;
  assign step_o    = cnt_q;
  assign done_o    = done_q;
  assign conv_en_o = en_q;
endmodule

// File: rtl/col_sar_trial.sv
module col_sar_trial #(
  parameter int NBITS = 10,
  parameter int CW    = 4
) (
  input  logic             search,
  input  logic [CW-1:0]    step,
  output logic [NBITS-1:0] code
);
  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    assign code[b] = search && (step == CW'(b));
  end
endmodule

// File: rtl/col_sar_bank.sv
module col_sar_bank #(
  parameter int NCOL  = 256,
  parameter int NBITS = 10,
  parameter int CW    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  cap,
  input  logic [CW-1:0]         step,
  input  logic [NCOL-1:0]       cmp,
  output logic [NCOL*NBITS-1:0] res
);
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [NBITS-1:0] code_q, code_d;
    logic             upd;

    assign upd = clr || cap;

    always_comb begin
      code_d = code_q;
      if (clr) begin
        code_d = '0;
      end else begin
        for (int b = 0; b < NBITS; b++) begin
          if (step == CW'(b)) code_d[b] = cmp[c];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   code_q <= '0;
      else if (upd) code_q <= code_d;
    end

    assign res[c*NBITS +: NBITS] = code_q;
  end
endmodule

// File: rtl/col_sar_ctrl.sv
module col_sar_ctrl
  import col_sar_pkg::*;
#(
  parameter int NCOL    = 256,
  parameter int NBITS   = 10,
  parameter int RST_CYC = 3,
  parameter int SIG_CYC = 3,
  parameter int OFS_CYC = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  sleep,
  input  logic [NCOL-1:0]       col_cmp,
  output logic                  conv_en,
  output logic                  samp_rst,
  output logic                  samp_sig,
  output logic                  ofs_cor,
  output logic [NBITS-1:0]      trial_code,
  output logic [NCOL*NBITS-1:0] results,
  output logic                  done
);
  localparam int MAXL = max2(max2(RST_CYC, SIG_CYC), max2(OFS_CYC, NBITS));
  localparam int CW   = $clog2(MAXL + 1);

  logic          rst_s1, rst_s2;
  conv_state_e   state;
  logic [CW-1:0] step;
  logic          accept;
  logic          search;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  col_sar_seq #(
    .NBITS(NBITS), .RST_CYC(RST_CYC), .SIG_CYC(SIG_CYC),
    .OFS_CYC(OFS_CYC), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_s2), .start(start), .sleep(sleep),
    .state_o(state), .step_o(step), .accept_o(accept),
    .done_o(done), .conv_en_o(conv_en)
  );

  assign search   = (state == ST_SRCH);
  assign samp_rst = (state == ST_RST);
  assign samp_sig = (state == ST_SIG);
  assign ofs_cor  = (state == ST_OFS);

  col_sar_trial #(.NBITS(NBITS), .CW(CW)) u_trial (
    .search(search), .step(step), .code(trial_code)
  );

  col_sar_bank #(.NCOL(NCOL), .NBITS(NBITS), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_s2), .clr(accept), .cap(search),
    .step(step), .cmp(col_cmp), .res(results)
  );
endmodule

// File: rtl/col_sar_ctrl_chk.sv
module col_sar_ctrl_chk #(
  parameter int NCOL  = 256,
  parameter int NBITS = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  sleep,
  input logic                  conv_en,
  input logic                  samp_rst,
  input logic                  samp_sig,
  input logic                  ofs_cor,
  input logic [NBITS-1:0]      trial_code,
  input logic [NCOL*NBITS-1:0] results,
  input logic                  done
);
  // R10
  excl_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({samp_rst, samp_sig, ofs_cor, |trial_code}) && $onehot0(trial_code));

  // R2
  sig_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(samp_sig) |-> $past(samp_rst));

  // R2
  ofs_after_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ofs_cor) |-> $past(samp_sig));

  // R3
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trial_code[NBITS-1] |-> $past(ofs_cor));

  // R3
  halving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((trial_code != '0) && !trial_code[NBITS-1]) |-> ($past(trial_code) == (trial_code << 1)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_after_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (($past(trial_code) == NBITS'(1)) && !$past(sleep)));

  // R8
  hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(results));

  // R9
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!conv_en && !samp_rst && !samp_sig && !ofs_cor && (trial_code == '0) && !done));
endmodule

bind col_sar_ctrl col_sar_ctrl_chk #(.NCOL(NCOL), .NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sleep(sleep), .conv_en(conv_en),
  .samp_rst(samp_rst), .samp_sig(samp_sig), .ofs_cor(ofs_cor),
  .trial_code(trial_code), .results(results), .done(done)
);

// File: tb/test_col_sar_ctrl.sv
`timescale 1ns/1ps
module test_col_sar_ctrl;
  localparam int NCOL = 256;
  localparam int NB   = 10;
  localparam int P1   = 3;
  localparam int P2   = 3;
  localparam int P3   = 2;
  localparam int LAT  = P1 + P2 + P3 + NB;

  logic              clk = 1'b0;
  logic              rst_n, start, sleep;
  logic [NCOL-1:0]   col_cmp;
  logic              conv_en, samp_rst, samp_sig, ofs_cor, done;
  logic [NB-1:0]     trial_code;
  logic [NCOL*NB-1:0] results;
  logic [NB-1:0]     vin [NCOL];
  logic [NB-1:0]     expv [NCOL];
  int                n_run = 0;
  int                n_fail = 0;

  always #2.5 clk = ~clk;

  col_sar_ctrl #(.NCOL(NCOL), .NBITS(NB), .RST_CYC(P1), .SIG_CYC(P2), .OFS_CYC(P3)) i_col_sar_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .sleep(sleep), .col_cmp(col_cmp),
    .conv_en(conv_en), .samp_rst(samp_rst), .samp_sig(samp_sig), .ofs_cor(ofs_cor),
    .trial_code(trial_code), .results(results), .done(done)
  );

  // ideal column comparators: input against own code plus trial weight
  always_comb begin
    for (int c = 0; c < NCOL; c++)
      col_cmp[c] = (vin[c] >= (results[c*NB +: NB] | trial_code));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int mode);
    for (int c = 0; c < NCOL; c++) begin
      case (mode)
        0: vin[c] = NB'(c * 4 + (c >> 6));
        1: vin[c] = '0;
        2: vin[c] = '1;
        3: vin[c] = (c % 2 == 0) ? NB'(511) : NB'(512);
        default: vin[c] = NB'((c * 37 + 11) % 1024);
      endcase
    end
  endtask

  function automatic int mism();
    int m = 0;
    for (int c = 0; c < NCOL; c++)
      if (results[c*NB +: NB] != expv[c]) m++;
    return m;
  endfunction

  // one conversion; busy != 0 pulses start twice while it runs
  task automatic run_conv(input int mode, input bit busy);
    int n, nr, ns, no, nt, first_sig, first_srch, clr_bad;
    fill(mode);
    for (int c = 0; c < NCOL; c++) expv[c] = vin[c];
    nr = 0; ns = 0; no = 0; nt = 0; first_sig = 0; first_srch = 0; clr_bad = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 1;
    if (results != '0) clr_bad = 1;
    while (n < 200) begin
      if (busy && (n == 4 || n == LAT - 2)) start = 1'b1;
      else start = 1'b0;
      nr += int'(samp_rst); ns += int'(samp_sig); no += int'(ofs_cor);
      if (samp_sig && first_sig == 0) first_sig = n;
      if (trial_code != '0) begin
        nt++;
        if (nt == 1) begin
          first_srch = n;
          chk(trial_code == NB'(512), "R3 first trial", int'(trial_code), 512);
        end
      end
      if (done) break;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(clr_bad == 0, "R4 clear on accept", clr_bad, 0);
    chk(nr == P1 && ns == P2 && no == P3, "R2 phase lengths", nr*100 + ns*10 + no, P1*100 + P2*10 + P3);
    chk(first_sig == P1 + 1, "R2 signal phase start", first_sig, P1 + 1);
    chk(nt == NB && first_srch == P1 + P2 + P3 + 1, "R3 search cycles", nt, NB);
    chk(n == LAT + 1, "R6 done cycle", n, LAT + 1);
    chk(mism() == 0, "R5 column codes", mism(), 0);
    @(negedge clk);
    chk(!done, "R6 done single cycle", int'(done), 0);
    if (busy) begin
      int extra = 0;
      for (int i = 0; i < 6; i++) begin
        extra += int'(samp_rst) + int'(done);
        @(negedge clk);
      end
      chk(extra == 0, "R7 busy start ignored", extra, 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; sleep = 1'b0;
    fill(1);
    repeat (3) @(negedge clk);
    chk(!done && !samp_rst && !samp_sig && !ofs_cor && trial_code == '0 && !conv_en,
        "R1 outputs in reset", int'(conv_en), 0);
    chk(results == '0, "R1 results in reset", int'(results[NB-1:0]), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && !samp_rst && trial_code == '0 && results == '0, "R1 after release",
        int'(samp_rst), 0);
  endtask

  task automatic t_partial();
    // R4: first search cycle decides MSB; visible one cycle later
    fill(3);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (P1 + P2 + P3 + 1) @(negedge clk);
    chk(results[NB-1:0] == NB'(0) && results[2*NB-1:NB] == NB'(512), "R4 MSB decision",
        int'(results[2*NB-1:NB]), 512);
    repeat (NB + 2) @(negedge clk);
  endtask

  task automatic t_hold();
    int m;
    run_conv(4, 1'b0);
    fill(2);
    repeat (20) @(negedge clk);
    m = mism();
    chk(m == 0, "R8 results held", m, 0);
  endtask

  task automatic t_sleep();
    int act = 0;
    @(negedge clk) sleep = 1'b1;
    @(negedge clk);
    chk(!conv_en, "R9 enable off", int'(conv_en), 0);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      act += int'(samp_rst) + int'(samp_sig) + int'(done);
      @(negedge clk);
    end
    chk(act == 0, "R9 start refused in sleep", act, 0);
    sleep = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (P1 + P2) @(negedge clk);
    sleep = 1'b1;
    @(negedge clk);
    chk(!samp_rst && !samp_sig && !ofs_cor && trial_code == '0, "R9 abort to idle",
        int'(ofs_cor), 0);
    sleep = 1'b0;
    act = 0;
    for (int i = 0; i < LAT + 4; i++) begin
      act += int'(done) + int'(trial_code != '0);
      @(negedge clk);
    end
    chk(act == 0, "R9 no done after abort", act, 0);
    chk(conv_en, "R9 enable restored", int'(conv_en), 1);
  endtask

  initial begin
    t_reset();
    run_conv(0, 1'b0);
    run_conv(1, 1'b0);
    run_conv(2, 1'b0);
    run_conv(3, 1'b0);
    t_partial();
    run_conv(4, 1'b1);
    t_hold();
    t_sleep();
    run_conv(0, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    n_run++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule